// File: doc/BRIEF.md
# Dual-Source SPI Master with Periodic and Queued Frames

This block is an SPI master that carries frames from two sources over one serial link. The periodic source resends the contents of a parallel data input each time an internal interval timer expires. The queued source sends words that were pushed into a small transmit FIFO. A two-bit mode input chooses periodic-only operation, queued-only operation, or a combined mode in which both sources share the link. After every frame the link stays idle for a programmable inter-frame gap. The next frame and its source are chosen at one fixed decision cycle at the end of that gap.

A push is registered into the FIFO on the clock edge where it arrives. The control logic reads the FIFO's registered fill state only at the decision cycle. A push that lands in the final cycles of the gap is therefore picked up at that decision point or the next one, and it can never cut into a frame. A halt request lets any frame in progress finish and then parks the master. A running status output reports whether the master is active or fully halted. A completion flag with a write-1-to-clear input and an interrupt enable marks the end of each frame. A single receive register captures the word shifted in on the data-in line during each frame.

Top module: `dualsrc_spi_master`

## Requirements
- R1: The mode input selects the sources. 2'b00 sends only periodic frames, and pushed words are held in the FIFO unsent. 2'b01 sends only queued frames. 2'b10 and 2'b11 send both.
- R2: When periodic frames are enabled and the link is otherwise free, periodic frames start exactly PERIOD_CYCLES clock cycles apart and carry the value of the periodic data input.
- R3: A frame is 16 bits, most significant bit first, with no skipped or extra bits. The chip select is low for the whole frame (64 clock cycles) and high otherwise. The serial clock runs at one quarter of the system clock and idles low. The data-out line changes while the serial clock is low. Queued words leave in push order.
- R4: Between the end of one frame and the start of the next, chip select stays high for at least DT_CYCLES+1 clock cycles. It stays high for exactly DT_CYCLES+1 cycles when the next frame is already waiting.
- R5: A push that arrives during the last two cycles of the inter-frame gap, or during the decision cycle, is sent later as a correctly framed 16-bit word with its exact value.
- R6: A halt request never shortens a frame in progress. Once halted, no frame starts until the request is released.
- R7: The running output is 1 out of reset and while the master may transmit. It goes to 0 only after a halt request has taken effect and the current frame and its gap are done. It returns to 1 within two cycles of the request being released.
- R8: Words pushed while halted are sent after release, ahead of any periodic frame that came due during the halt.
- R9: The completion flag is set at the end of every frame. The interrupt output is 1 exactly when the flag and the interrupt enable are both 1.
- R10: Driving the clear input high for one cycle clears the completion flag (write 1 to clear). If a frame ends in the same cycle, the flag stays set.
- R11: When a queued word and a due periodic frame are both ready at a decision point, the queued word is sent first. The periodic frame follows at the next free slot and is not dropped.
- R12: The FIFO holds 4 words. A push while it is full is discarded, and the overflow flag is set. The flag stays set until reset.
- R13: The data-in line is captured once per bit while the serial clock is high, most significant bit first. The completed word appears on the receive output at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Source selection (see R1) |
| periodData | input | 16 | Word sent by periodic frames |
| pushValid | input | 1 | Push strobe for the transmit FIFO |
| pushData | input | 16 | Word to push |
| haltReq | input | 1 | Halt control bit, level sensitive |
| tcfClear | input | 1 | Write-1-to-clear for the completion flag |
| tcfIrqEn | input | 1 | Interrupt enable for the completion flag |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Chip select, active low |
| running | output | 1 | 1 while active, 0 when fully halted |
| tcfFlag | output | 1 | Frame completion flag |
| irq | output | 1 | Completion interrupt |
| overflowFlag | output | 1 | Sticky FIFO overflow flag |
| rxData | output | 16 | Last received word |

## Verification
Assertions inside the control and datapath modules check the following on every cycle:
- no frame load while a frame is active, and no frame cut short;
- the minimum inter-frame gap, measured against a separate counter;
- the completion flag's set-wins and clear behaviour;
- the FIFO fill bound and the stickiness of the overflow flag;
- a queued load only when the FIFO is not empty;
- the running bit dropping only under a halt request.

Other behaviours only the bench's scenarios can show:
- the exact bit content and order of frames;
- the exact period spacing;
- which source wins a tied decision and that the loser is still sent;
- the fate of pushes landing in the final gap cycles;
- the dropping of the fifth push into a full FIFO.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
package dsm_pkg;

  // Source selection codes on modeSel
  localparam logic [1:0] MODE_PERIODIC_ONLY = 2'b00;
  localparam logic [1:0] MODE_QUEUED_ONLY   = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_HALTED
  } dsm_state_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadQueued;
    logic loadPeriodic;
    logic frameActive;
  } dsm_strobe_t;

endpackage

// File: rtl/dsm_datapath.sv
`timescale 1ns/1ps
module dsm_datapath
  import dsm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dsm_strobe_t       strobe,
  input  logic [DATA_W-1:0] periodData,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              miso,
  output logic              fifoEmpty,
  output logic              frameDone,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic              overflowFlag,
  output logic [DATA_W-1:0] rxData
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  // ---------------- transmit push FIFO ----------------
  logic [DATA_W-1:0] slots [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  level;
  logic              fifoFull;
  logic              pushOk;
  logic              popNow;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign fifoFull  = (level == FULL_LVL);
  assign fifoEmpty = (level == '0);
  assign pushOk    = pushValid && !fifoFull;
  assign popNow    = strobe.loadQueued;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      level        <= '0;
      overflowFlag <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popNow) rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popNow})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: ;
      endcase
      if (pushValid && fifoFull) overflowFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) slots[wrPtr] <= pushData;
  end

  // ---------------- shifter and bit timing ----------------
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              loadAny;
  logic              lastPhase;

  assign loadAny   = strobe.loadQueued || strobe.loadPeriodic;
  assign lastPhase = (divCnt == DIV_LAST);
  assign frameDone = strobe.frameActive && lastPhase && (bitCnt == BIT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      rxData  <= '0;
    end else begin
      if (loadAny) begin
        txShift <= strobe.loadQueued ? slots[rdPtr] : periodData;
        divCnt  <= '0;
        bitCnt  <= '0;
      end else if (strobe.frameActive) begin
        divCnt <= lastPhase ? '0 : divCnt + 1'b1;
        if (divCnt == DIV_HALF) rxShift <= {rxShift[DATA_W-2:0], miso};
        if (lastPhase) begin
          txShift <= {txShift[DATA_W-2:0], 1'b0};
          bitCnt  <= bitCnt + 1'b1;
        end
      end
      if (frameDone) rxData <= rxShift;
    end
  end

  assign sclk = strobe.frameActive && (divCnt >= DIV_HALF);
  assign mosi = strobe.frameActive && txShift[DATA_W-1];
  assign csN  = !strobe.frameActive;

  // ---------------- assertions ----------------
  assert_load_between_frames_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadAny |-> !strobe.frameActive);

  assert_cs_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameActive && !frameDone) |=> !csN);

  assert_level_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);

  assert_overflow_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadQueued |-> !fifoEmpty);

endmodule

// File: rtl/dsm_ctrl.sv
`timescale 1ns/1ps
module dsm_ctrl
  import dsm_pkg::*;
#(
  parameter int DT_CYCLES     = 6,
  parameter int PERIOD_CYCLES = 300
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic        haltReq,
  input  logic        tcfClear,
  input  logic        tcfIrqEn,
  input  logic        fifoEmpty,
  input  logic        frameDone,
  output dsm_strobe_t strobe,
  output logic        running,
  output logic        tcfFlag,
  output logic        irq
);

  localparam int DT_W  = $clog2(DT_CYCLES + 1);
  localparam int PER_W = $clog2(PERIOD_CYCLES);
  localparam logic [DT_W-1:0]  DT_LAST  = DT_W'(DT_CYCLES - 1);
  localparam logic [DT_W-1:0]  DT_FULL  = DT_W'(DT_CYCLES);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_CYCLES - 1);

  dsm_state_e       state;
  dsm_state_e       stateNext;
  logic [DT_W-1:0]  dtCnt;
  logic [PER_W-1:0] perCnt;
  logic             perWrap;
  logic             periodPending;
  logic             periodicOn;
  logic             queuedOn;
  logic             startQueued;
  logic             startPeriodic;

  assign periodicOn = (modeSel != MODE_QUEUED_ONLY);
  assign queuedOn   = (modeSel != MODE_PERIODIC_ONLY);
  assign perWrap    = (perCnt == PER_LAST);

  // Period timer: one pending slot, kept until a periodic frame is loaded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt        <= '0;
      periodPending <= 1'b0;
    end else if (!periodicOn) begin
      perCnt        <= '0;
      periodPending <= 1'b0;
    end else begin
      perCnt <= perWrap ? '0 : perCnt + 1'b1;
      if (perWrap)            periodPending <= 1'b1;
      else if (startPeriodic) periodPending <= 1'b0;
    end
  end

  // Single decision point: only in ST_IDLE, queued source first
  assign startQueued   = (state == ST_IDLE) && !haltReq && queuedOn && !fifoEmpty;
  assign startPeriodic = (state == ST_IDLE) && !haltReq && periodicOn && periodPending
                         && !startQueued;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (haltReq)                          stateNext = ST_HALTED;
        else if (startQueued || startPeriodic) stateNext = ST_SHIFT;
      end
      ST_SHIFT:  if (frameDone)          stateNext = ST_GAP;
      ST_GAP:    if (dtCnt == DT_LAST)   stateNext = ST_IDLE;
      ST_HALTED: if (!haltReq)           stateNext = ST_IDLE;
      default:                           stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      dtCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_GAP) dtCnt <= dtCnt + 1'b1;
      else                 dtCnt <= '0;
    end
  end

  // Completion flag: set wins over the write-1 clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         tcfFlag <= 1'b0;
    else if (frameDone) tcfFlag <= 1'b1;
    else if (tcfClear)  tcfFlag <= 1'b0;
  end

  assign irq                 = tcfFlag && tcfIrqEn;
  assign running             = (state != ST_HALTED);
  assign strobe.loadQueued   = startQueued;
  assign strobe.loadPeriodic = startPeriodic;
  assign strobe.frameActive  = (state == ST_SHIFT);

  // ---------------- assertions ----------------
  // Independent gap counter, saturating at DT_CYCLES
  logic [DT_W-1:0] gapSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 gapSeen <= DT_FULL;
    else if (frameDone)        gapSeen <= '0;
    else if (gapSeen < DT_FULL) gapSeen <= gapSeen + 1'b1;
  end

  assert_dt_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startQueued || startPeriodic) |-> (gapSeen == DT_FULL));

  assert_no_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameActive && !frameDone) |=> strobe.frameActive);

  assert_halt_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(haltReq));

  assert_tcf_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> tcfFlag);

  assert_tcf_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tcfClear && !frameDone) |=> !tcfFlag);

endmodule

// File: rtl/dualsrc_spi_master.sv
`timescale 1ns/1ps
module dualsrc_spi_master
  import dsm_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int FIFO_DEPTH    = 4,
  parameter int CLK_DIV       = 4,
  parameter int DT_CYCLES     = 6,
  parameter int PERIOD_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [DATA_W-1:0] periodData,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              haltReq,
  input  logic              tcfClear,
  input  logic              tcfIrqEn,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic              running,
  output logic              tcfFlag,
  output logic              irq,
  output logic              overflowFlag,
  output logic [DATA_W-1:0] rxData
);

  dsm_strobe_t strobe;
  logic        fifoEmpty;
  logic        frameDone;

  dsm_ctrl #(
    .DT_CYCLES    (DT_CYCLES),
    .PERIOD_CYCLES(PERIOD_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .haltReq  (haltReq),
    .tcfClear (tcfClear),
    .tcfIrqEn (tcfIrqEn),
    .fifoEmpty(fifoEmpty),
    .frameDone(frameDone),
    .strobe   (strobe),
    .running  (running),
    .tcfFlag  (tcfFlag),
    .irq      (irq)
  );

  dsm_datapath #(
    .DATA_W    (DATA_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .CLK_DIV   (CLK_DIV)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .periodData  (periodData),
    .pushValid   (pushValid),
    .pushData    (pushData),
    .miso        (miso),
    .fifoEmpty   (fifoEmpty),
    .frameDone   (frameDone),
    .sclk        (sclk),
    .mosi        (mosi),
    .csN         (csN),
    .overflowFlag(overflowFlag),
    .rxData      (rxData)
  );

endmodule

// File: tb/dualsrc_spi_master_test.sv
`timescale 1ns/1ps
module dualsrc_spi_master_test;

  localparam int W   = 16;
  localparam int DT  = 6;
  localparam int PER = 300;
  localparam logic [W-1:0] PDATA = 16'hA5C3;
  // {pushed word, word the slave returns}
  localparam logic [31:0] VEC [0:5] = '{
    32'h8001_F00F, 32'h0001_8000, 32'hFFFF_0000,
    32'h0000_FFFF, 32'h5AA5_3CC3, 32'h7FFE_1248
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b01;
  logic [W-1:0] periodData = PDATA;
  logic pushValid = 1'b0;
  logic [W-1:0] pushData = '0;
  logic haltReq = 1'b0;
  logic tcfClear = 1'b0;
  logic tcfIrqEn = 1'b0;
  logic miso = 1'b0;
  logic sclk, mosi, csN, running, tcfFlag, irq, overflowFlag;
  logic [W-1:0] rxData;

  always #2.5 clk = ~clk;

  dualsrc_spi_master #(.DATA_W(W), .FIFO_DEPTH(4), .CLK_DIV(4),
                       .DT_CYCLES(DT), .PERIOD_CYCLES(PER)) uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .periodData(periodData),
    .pushValid(pushValid), .pushData(pushData), .haltReq(haltReq),
    .tcfClear(tcfClear), .tcfIrqEn(tcfIrqEn), .miso(miso), .sclk(sclk),
    .mosi(mosi), .csN(csN), .running(running), .tcfFlag(tcfFlag), .irq(irq),
    .overflowFlag(overflowFlag), .rxData(rxData));

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- link monitor ----------------
  logic [W-1:0] curWord = '0;
  int curBits = 0;
  logic [W-1:0] capWord [64];
  int capBits [64];
  int capStart [64];
  int capCnt = 0;
  int highRun = 1000;
  int lastGap = 0;
  int negCyc = 0;
  logic [W-1:0] misoWord = '0;
  logic [W-1:0] misoSh = '0;

  always @(negedge csN) if (rstN) begin
    curBits = 0;
    curWord = '0;
    misoSh = misoWord;
    miso = misoWord[W-1];
  end
  always @(posedge sclk) if (rstN && !csN) begin
    curWord = {curWord[W-2:0], mosi};
    curBits++;
  end
  always @(negedge sclk) if (rstN && !csN) begin
    misoSh = misoSh << 1;
    miso = misoSh[W-1];
  end
  always @(posedge csN) if (rstN) begin
    capWord[capCnt % 64] = curWord;
    capBits[capCnt % 64] = curBits;
    capCnt++;
  end
  always @(negedge clk) if (rstN) begin
    negCyc++;
    if (csN === 1'b1) highRun++;
    else if (highRun != 0) begin
      lastGap = highRun;
      capStart[capCnt % 64] = negCyc;
      highRun = 0;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic push(logic [W-1:0] d);
    pushValid = 1'b1;
    pushData = d;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic waitCount(int target);
    int t = 0;
    while (capCnt < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  task automatic waitRunning(logic v);
    int t = 0;
    while (running !== v && t < 2000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic pulseClear();
    tcfClear = 1'b1;
    @(negedge clk);
    tcfClear = 1'b0;
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R3", "reset csN", csN, 1);
    check("R3", "reset sclk", sclk, 0);
    check("R7", "reset running", running, 1);
    check("R9", "reset tcf", tcfFlag, 0);
    check("R9", "reset irq", irq, 0);
    check("R12", "reset overflow", overflowFlag, 0);

    // table of queued frames, mode 01
    for (int i = 0; i < 6; i++) begin
      base = capCnt;
      misoWord = VEC[i][15:0];
      push(VEC[i][31:16]);
      waitCount(base + 1);
      check("R3", "queued word", capWord[base % 64], VEC[i][31:16]);
      check("R3", "bit count", capBits[base % 64], 16);
      check("R13", "rx word", rxData, VEC[i][15:0]);
      check("R9", "tcf set", tcfFlag, 1);
      pulseClear();
      check("R10", "tcf cleared", tcfFlag, 0);
    end

    // back-to-back: exact gap and push order
    base = capCnt;
    push(16'h1111); push(16'h2222); push(16'h3333);
    waitCount(base + 3);
    check("R3", "order 0", capWord[base % 64], 16'h1111);
    check("R3", "order 1", capWord[(base + 1) % 64], 16'h2222);
    check("R3", "order 2", capWord[(base + 2) % 64], 16'h3333);
    check("R4", "gap back-to-back", lastGap, DT + 1);

    // late pushes in the final gap cycles and the decision cycle
    for (int k = DT - 2; k <= DT; k++) begin
      base = capCnt;
      push(16'h7100 + 16'(k));
      @(posedge csN);
      repeat (k + 1) @(negedge clk);
      push(16'hC700 + 16'(k));
      waitCount(base + 2);
      check("R5", "late push word", capWord[(base + 1) % 64], 16'hC700 + 16'(k));
      check("R5", "late push bits", capBits[(base + 1) % 64], 16);
      check("R4", "late push gap", (lastGap >= DT + 1), 1);
    end

    // periodic-only: spacing, content, queued word held
    modeSel = 2'b00;
    base = capCnt;
    push(16'h0F0F);
    waitCount(base + 3);
    check("R1", "periodic 0", capWord[base % 64], PDATA);
    check("R1", "periodic 1", capWord[(base + 1) % 64], PDATA);
    check("R2", "periodic 2", capWord[(base + 2) % 64], PDATA);
    check("R2", "spacing a", capStart[(base + 1) % 64] - capStart[base % 64], PER);
    check("R2", "spacing b", capStart[(base + 2) % 64] - capStart[(base + 1) % 64], PER);
    modeSel = 2'b01;
    waitCount(base + 4);
    check("R1", "held word sent in queued mode", capWord[(base + 3) % 64], 16'h0F0F);

    // combined mode: tie at the decision point after a halt
    modeSel = 2'b10;
    haltReq = 1'b1;
    waitRunning(1'b0);
    check("R7", "halted running", running, 0);
    base = capCnt;
    repeat (PER + 20) @(negedge clk);
    push(16'h1234);
    repeat (20) @(negedge clk);
    check("R6", "no frame while halted", capCnt, base);
    haltReq = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", "running after release", running, 1);
    waitCount(base + 2);
    check("R8", "queued first after halt", capWord[base % 64], 16'h1234);
    check("R11", "periodic not dropped", capWord[(base + 1) % 64], PDATA);

    // halt during a frame
    modeSel = 2'b01;
    waitCount(capCnt);
    repeat (DT + 4) @(negedge clk);
    base = capCnt;
    push(16'hBEEF);
    @(negedge csN);
    repeat (10) @(negedge clk);
    haltReq = 1'b1;
    @(negedge clk);
    check("R7", "running during frame", running, 1);
    waitCount(base + 1);
    check("R6", "halted frame word", capWord[base % 64], 16'hBEEF);
    check("R6", "halted frame bits", capBits[base % 64], 16);
    repeat (DT + 4) @(negedge clk);
    check("R7", "running after halt", running, 0);
    push(16'h5555);
    repeat (200) @(negedge clk);
    check("R6", "halt holds", capCnt, base + 1);
    haltReq = 1'b0;
    repeat (2) @(negedge clk);
    check("R7", "running resumes", running, 1);
    waitCount(base + 2);
    check("R8", "halted push sent", capWord[(base + 1) % 64], 16'h5555);

    // completion flag: set wins over clear, interrupt gating
    repeat (DT + 4) @(negedge clk);
    pulseClear();
    check("R10", "flag cleared", tcfFlag, 0);
    tcfIrqEn = 1'b1;
    push(16'h3C3C);
    @(negedge csN);
    repeat (64) @(negedge clk);
    tcfClear = 1'b1;
    @(negedge clk);
    tcfClear = 1'b0;
    check("R3", "cs high after 64 cycles", csN, 1);
    check("R10", "set wins over clear", tcfFlag, 1);
    check("R9", "irq with enable", irq, 1);
    pulseClear();
    check("R9", "irq after clear", irq, 0);
    tcfIrqEn = 1'b0;
    base = capCnt;
    push(16'h4242);
    waitCount(base + 1);
    check("R9", "flag set enable off", tcfFlag, 1);
    check("R9", "irq masked", irq, 0);

    // overflow
    check("R12", "no overflow yet", overflowFlag, 0);
    haltReq = 1'b1;
    waitRunning(1'b0);
    for (int i = 0; i < 5; i++) push(16'hC000 + 16'(i));
    check("R12", "overflow set", overflowFlag, 1);
    base = capCnt;
    haltReq = 1'b0;
    waitCount(base + 4);
    for (int i = 0; i < 4; i++)
      check("R12", "kept word", capWord[(base + i) % 64], 16'hC000 + 16'(i));
    repeat (300) @(negedge clk);
    check("R12", "fifth push dropped", capCnt, base + 4);
    check("R12", "overflow sticky", overflowFlag, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule